// File: doc/BRIEF.md
# Translation Lookaside Buffer with Mixed Page Sizes

This block is a fully associative address translation buffer. Each entry pairs a virtual tag with a translation record. The tag holds the virtual address, with the owning context number packed into its low bits. The record holds a physical page number and a set of attribute flags. Every entry chooses its own page size: 8 KB, 64 KB, 512 KB or 4 MB. That size sets how many tag bits take part in the compare, and how many low virtual address bits pass straight into the physical address.

A request gives a virtual address, says whether it is an instruction fetch or a data access (load, store or non-faulting load), and carries the privilege and trap-level state. For data, it also says which context register applies: primary, secondary or nucleus. All entries are compared in parallel. One cycle later the block reports exactly one outcome: a hit with the physical address and access rights, a miss, a fault, or a protection trap.

Faults and protection traps load a fault status word and a fault address register. Misses, faults and protection traps all load a tag-access register that a refill handler can use. Entries are loaded through a plain indexed write port, and the refill logic outside the block chooses which slot to replace.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, and fault_status, fault_addr, tag_access and used_bits are all 0.
- R2: A request accepted on a clock edge produces rsp_valid on that same edge. When rsp_valid is 1, exactly one of rsp_hit, rsp_miss, rsp_fault and rsp_prot is 1. When rsp_valid is 0, none of them is 1.
- R3: An entry matches when three conditions hold: it is valid; it is global or its tag bits [12:0] equal the request context; and the virtual address equals the tag once both are ANDed with the mask ~((8192 << 3*size) - 1). Size codes 0, 1, 2 and 3 select 8 KB, 64 KB, 512 KB and 4 MB pages.
- R4: When several entries match, the entry with the lowest index decides the result.
- R5: On a hit, rsp_pa is ((entry_pa & mask) | (va & ~mask)), cut to 41 bits, with bits [12:0] forced to zero.
- R6: A data request takes its context from req_ctx_sel. Code 0 selects primary_ctx, code 1 selects secondary_ctx, and codes 2 or 3 select nucleus (context 0). A fetch uses primary_ctx when req_tl_nz is 0 and context 0 otherwise, and req_ctx_sel has no effect on a fetch.
- R7: A data fault occurs on any of three conditions: a privileged page accessed by a user request; a non-faulting load (req_kind 2) to a side-effect page; or a load (0) or store (1) to a no-fault-only page. Several of these fault reasons can be recorded in the same status word.
- R8: A data store to a non-writable page with no fault from R7 gives rsp_prot.
- R9: On rsp_fault or rsp_prot, fault_status is loaded with these fields:
  - bit0: valid = 1.
  - bit1: overflow = the previous bit0.
  - bit2: req_priv_mode.
  - bits[4:3]: context type, 0 for primary, 1 for secondary, 2 for nucleus.
  - bit5: store.
  - bit6: non-faulting load.
  - bit7: privilege fault.
  - bit8: side-effect fault.
  - bit9: no-fault-only fault.

  fault_addr is loaded with the virtual address.
- R10: On a miss, fault or protection trap, tag_access is loaded with the virtual address, with bits [12:0] replaced by the request context. A miss leaves fault_status and fault_addr unchanged.
- R11: The only fault a fetch can raise is a privileged page accessed by a user request. Its status word records context type 2 when req_tl_nz is 1 and 0 otherwise. A fetch hit gives rsp_exec=1, rsp_rd=0, rsp_wr=0 and rsp_swap=0.
- R12: A data hit gives rsp_rd=1 and rsp_exec=0. It gives rsp_wr equal to the entry's writable bit and rsp_swap equal to the entry's invert-endian bit.
- R13: A hit without a fault or protection trap sets the used bit of the winning entry. Writing an entry clears that entry's used bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Entry slot to write |
| wr_tag | input | VA_W | Virtual tag, context in bits [12:0] |
| wr_valid | input | 1 | Entry valid flag |
| wr_global | input | 1 | Entry matches any context |
| wr_size | input | 2 | Page size code |
| wr_priv | input | 1 | Page restricted to privileged requests |
| wr_writable | input | 1 | Page writable |
| wr_side_eff | input | 1 | Page has side effects |
| wr_nfo | input | 1 | Page only for non-faulting loads |
| wr_swap | input | 1 | Invert endianness on access |
| wr_pa | input | PA_W | Physical page address |
| primary_ctx | input | CTX_W | Primary context register |
| secondary_ctx | input | CTX_W | Secondary context register |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address |
| req_fetch | input | 1 | Instruction fetch (1) or data access (0) |
| req_kind | input | 2 | Data access kind: 0 load, 1 store, 2 non-faulting load |
| req_ctx_sel | input | 2 | Data context select |
| req_user | input | 1 | Request made in user mode |
| req_priv_mode | input | 1 | Privileged-mode state for the status word |
| req_tl_nz | input | 1 | Trap level nonzero |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Access fault |
| rsp_prot | output | 1 | Write protection trap |
| rsp_pa | output | PA_W | Physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_exec | output | 1 | Execute permitted |
| rsp_swap | output | 1 | Byte swap required |
| fault_status | output | 10 | Fault status word |
| fault_addr | output | VA_W | Fault address register |
| tag_access | output | VA_W | Tag-access register |
| used_bits | output | N_ENTRIES | Per-entry used flags |

## Verification
The bench builds the block with N_ENTRIES=16, a 64-bit virtual address and a 41-bit physical address. With only sixteen slots, random refills often overwrite live entries. They also often leave two entries covering the same address with different sizes or contexts, which exercises lowest-index priority and overlapping large and small pages. Restricting random tags to a few high-order address patterns and three context values makes hits, context mismatches, global matches and overflowing fault status words all common in the random phase.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

   typedef struct packed {
      logic       valid;
      logic       global;
      logic [1:0] size;
      logic       priv;
      logic       writable;
      logic       side_eff;
      logic       nfo;
      logic       swap;
   } tte_flags_t;

   typedef enum logic [1:0] {
      CTX_PRIMARY   = 2'd0,
      CTX_SECONDARY = 2'd1,
      CTX_NUCLEUS   = 2'd2
   } ctx_kind_e;

   typedef enum logic [1:0] {
      ACC_LOAD   = 2'd0,
      ACC_STORE  = 2'd1,
      ACC_NFLOAD = 2'd2
   } acc_kind_e;

   localparam int ST_W       = 10;
   localparam int ST_VALID   = 0;
   localparam int ST_OVF     = 1;
   localparam int ST_PMODE   = 2;
   localparam int ST_CTX_LO  = 3;
   localparam int ST_STORE   = 5;
   localparam int ST_NFLOAD  = 6;
   localparam int ST_FT_PRIV = 7;
   localparam int ST_FT_SE   = 8;
   localparam int ST_FT_NFO  = 9;

endpackage

// File: rtl/tlbx_pgmask.sv
module tlbx_pgmask #(
   parameter int VA_W       = 64,
   parameter int PAGE_SHIFT = 13,
   parameter int SIZE_STEP  = 3
) (
   input  logic [1:0]      size,
   output logic [VA_W-1:0] mask
);
   localparam int MAX_SHIFT = PAGE_SHIFT + 3 * SIZE_STEP;

   if (MAX_SHIFT >= VA_W) begin : g_bad_width
      $error("tlbx_pgmask: largest page does not fit in VA_W");
   end

   logic [VA_W-1:0] span;

   always_comb begin
      span = {{(VA_W-1){1'b0}}, 1'b1} << (PAGE_SHIFT + SIZE_STEP * int'(size));
      mask = ~(span - {{(VA_W-1){1'b0}}, 1'b1});
   end
endmodule

// File: rtl/tlbx_cam.sv
module tlbx_cam
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES  = 64,
   parameter int VA_W       = 64,
   parameter int CTX_W      = 13,
   parameter int PAGE_SHIFT = 13,
   parameter int SIZE_STEP  = 3
) (
   input  logic [N_ENTRIES-1:0][VA_W-1:0] tags,
   input  tte_flags_t [N_ENTRIES-1:0]     flags,
   input  logic [VA_W-1:0]                va,
   input  logic [CTX_W-1:0]               ctx,
   output logic [N_ENTRIES-1:0]           hits
);
   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_way
      logic [VA_W-1:0] way_mask;
      logic            ctx_ok;
      logic            addr_ok;

      tlbx_pgmask #(
         .VA_W      (VA_W),
         .PAGE_SHIFT(PAGE_SHIFT),
         .SIZE_STEP (SIZE_STEP)
      ) u_mask (
         .size(flags[i].size),
         .mask(way_mask)
      );

      always_comb begin
         ctx_ok  = flags[i].global || (tags[i][CTX_W-1:0] == ctx);
         addr_ok = ((va & way_mask) == (tags[i] & way_mask));
         hits[i] = flags[i].valid && ctx_ok && addr_ok;
      end
   end
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick #(
   parameter int N_ENTRIES = 64,
   parameter int IDX_W     = 6
) (
   input  logic [N_ENTRIES-1:0] req,
   output logic                 any,
   output logic [IDX_W-1:0]     idx
);
   if ((1 << IDX_W) < N_ENTRIES) begin : g_bad_idx
      $error("tlbx_pick: IDX_W too narrow for N_ENTRIES");
   end

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/tlbx_check.sv
module tlbx_check
   import tlbx_pkg::*;
(
   input  tte_flags_t f,
   input  logic       fetch,
   input  logic [1:0] kind,
   input  logic       user,
   output logic       ft_priv,
   output logic       ft_se,
   output logic       ft_nfo,
   output logic       fault,
   output logic       prot,
   output logic       perm_rd,
   output logic       perm_wr,
   output logic       perm_x
);
   logic is_nf;
   logic is_st;

   always_comb begin
      is_nf   = !fetch && (kind == ACC_NFLOAD);
      is_st   = !fetch && (kind == ACC_STORE);
      ft_priv = f.priv && user;
      ft_se   = is_nf && f.side_eff;
      ft_nfo  = !fetch && !is_nf && f.nfo;
      fault   = ft_priv || ft_se || ft_nfo;
      prot    = !fault && is_st && !f.writable;
      perm_rd = !fetch;
      perm_wr = !fetch && f.writable;
      perm_x  = fetch;
   end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES  = 64,
   parameter int VA_W       = 64,
   parameter int PA_W       = 41,
   parameter int CTX_W      = 13,
   parameter int PAGE_SHIFT = 13,
   parameter int SIZE_STEP  = 3,
   localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [VA_W-1:0]       wr_tag,
   input  logic                  wr_valid,
   input  logic                  wr_global,
   input  logic [1:0]            wr_size,
   input  logic                  wr_priv,
   input  logic                  wr_writable,
   input  logic                  wr_side_eff,
   input  logic                  wr_nfo,
   input  logic                  wr_swap,
   input  logic [PA_W-1:0]       wr_pa,
   input  logic [CTX_W-1:0]      primary_ctx,
   input  logic [CTX_W-1:0]      secondary_ctx,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  req_fetch,
   input  logic [1:0]            req_kind,
   input  logic [1:0]            req_ctx_sel,
   input  logic                  req_user,
   input  logic                  req_priv_mode,
   input  logic                  req_tl_nz,
   output logic                  rsp_valid,
   output logic                  rsp_hit,
   output logic                  rsp_miss,
   output logic                  rsp_fault,
   output logic                  rsp_prot,
   output logic [PA_W-1:0]       rsp_pa,
   output logic                  rsp_rd,
   output logic                  rsp_wr,
   output logic                  rsp_exec,
   output logic                  rsp_swap,
   output logic [ST_W-1:0]       fault_status,
   output logic [VA_W-1:0]       fault_addr,
   output logic [VA_W-1:0]       tag_access,
   output logic [N_ENTRIES-1:0]  used_bits
);
   localparam logic [VA_W-1:0] PA_KEEP   = VA_W'({PA_W{1'b1}});
   localparam logic [VA_W-1:0] PAGE_LOW  = VA_W'({PAGE_SHIFT{1'b1}});

   if (CTX_W > PAGE_SHIFT) begin : g_bad_ctx
      $error("tlb_xlate: context must fit below the page offset");
   end
   if (PA_W > VA_W) begin : g_bad_pa
      $error("tlb_xlate: PA_W must not exceed VA_W");
   end
   if (N_ENTRIES < 2) begin : g_bad_n
      $error("tlb_xlate: at least two entries are required");
   end

   // ---------------- entry storage ----------------
   logic [N_ENTRIES-1:0][VA_W-1:0] tag_q;
   logic [N_ENTRIES-1:0][PA_W-1:0] pa_q;
   tte_flags_t [N_ENTRIES-1:0]     flags_q;
   logic [N_ENTRIES-1:0]           used_q;

   // ---------------- request context ----------------
   logic [CTX_W-1:0] req_ctx;
   logic [1:0]       req_ctype;

   always_comb begin
      if (req_fetch) begin
         req_ctx   = req_tl_nz ? '0 : primary_ctx;
         req_ctype = req_tl_nz ? CTX_NUCLEUS : CTX_PRIMARY;
      end else begin
         unique case (req_ctx_sel)
            2'd0:    begin req_ctx = primary_ctx;   req_ctype = CTX_PRIMARY;   end
            2'd1:    begin req_ctx = secondary_ctx; req_ctype = CTX_SECONDARY; end
            default: begin req_ctx = '0;            req_ctype = CTX_NUCLEUS;   end
         endcase
      end
   end

   // ---------------- parallel match ----------------
   logic [N_ENTRIES-1:0] hit_vec;
   logic                 any_hit;
   logic [IDX_W-1:0]     win_idx;

   tlbx_cam #(
      .N_ENTRIES (N_ENTRIES),
      .VA_W      (VA_W),
      .CTX_W     (CTX_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .SIZE_STEP (SIZE_STEP)
   ) u_cam (
      .tags (tag_q),
      .flags(flags_q),
      .va   (req_va),
      .ctx  (req_ctx),
      .hits (hit_vec)
   );

   tlbx_pick #(
      .N_ENTRIES(N_ENTRIES),
      .IDX_W    (IDX_W)
   ) u_pick (
      .req(hit_vec),
      .any(any_hit),
      .idx(win_idx)
   );

   tte_flags_t      win_flags;
   logic [PA_W-1:0] win_pa;
   logic [VA_W-1:0] win_mask;

   always_comb begin
      win_flags = flags_q[win_idx];
      win_pa    = pa_q[win_idx];
   end

   tlbx_pgmask #(
      .VA_W      (VA_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .SIZE_STEP (SIZE_STEP)
   ) u_win_mask (
      .size(win_flags.size),
      .mask(win_mask)
   );

   // ---------------- permission and fault check ----------------
   logic ft_priv, ft_se, ft_nfo, chk_fault, chk_prot;
   logic perm_rd, perm_wr, perm_x;

   tlbx_check u_check (
      .f      (win_flags),
      .fetch  (req_fetch),
      .kind   (req_kind),
      .user   (req_user),
      .ft_priv(ft_priv),
      .ft_se  (ft_se),
      .ft_nfo (ft_nfo),
      .fault  (chk_fault),
      .prot   (chk_prot),
      .perm_rd(perm_rd),
      .perm_wr(perm_wr),
      .perm_x (perm_x)
   );

   // ---------------- physical address and status word ----------------
   logic [VA_W-1:0] pa_wide;
   logic [PA_W-1:0] pa_out;
   logic [VA_W-1:0] ta_next;
   logic [ST_W-1:0] st_next;
   logic            lk_fault, lk_prot, lk_ok;

   always_comb begin
      pa_wide  = ((VA_W'(win_pa) & win_mask) | (req_va & ~win_mask)) & PA_KEEP & ~PAGE_LOW;
      pa_out   = pa_wide[PA_W-1:0];
      ta_next  = (req_va & ~PAGE_LOW) | VA_W'(req_ctx);
      lk_fault = any_hit && chk_fault;
      lk_prot  = any_hit && chk_prot;
      lk_ok    = any_hit && !chk_fault && !chk_prot;

      st_next                          = '0;
      st_next[ST_VALID]                = 1'b1;
      st_next[ST_OVF]                  = fault_status[ST_VALID];
      st_next[ST_PMODE]                = req_priv_mode;
      st_next[ST_CTX_LO+1:ST_CTX_LO]   = req_ctype;
      st_next[ST_STORE]                = !req_fetch && (req_kind == ACC_STORE);
      st_next[ST_NFLOAD]               = !req_fetch && (req_kind == ACC_NFLOAD);
      st_next[ST_FT_PRIV]              = ft_priv;
      st_next[ST_FT_SE]                = ft_se;
      st_next[ST_FT_NFO]               = ft_nfo;
   end

   // ---------------- entry state ----------------
   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         pa_q[wr_idx]  <= wr_pa;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         used_q  <= '0;
      end else begin
         if (req_valid && lk_ok) used_q[win_idx] <= 1'b1;
         if (wr_en) begin
            flags_q[wr_idx] <= '{valid: wr_valid, global: wr_global, size: wr_size,
                                 priv: wr_priv, writable: wr_writable,
                                 side_eff: wr_side_eff, nfo: wr_nfo, swap: wr_swap};
            used_q[wr_idx]  <= 1'b0;
         end
      end
   end

   // ---------------- response and fault registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_prot     <= 1'b0;
         rsp_pa       <= '0;
         rsp_rd       <= 1'b0;
         rsp_wr       <= 1'b0;
         rsp_exec     <= 1'b0;
         rsp_swap     <= 1'b0;
         fault_status <= '0;
         fault_addr   <= '0;
         tag_access   <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && lk_ok;
         rsp_miss  <= req_valid && !any_hit;
         rsp_fault <= req_valid && lk_fault;
         rsp_prot  <= req_valid && lk_prot;
         rsp_pa    <= (req_valid && lk_ok) ? pa_out : '0;
         rsp_rd    <= req_valid && lk_ok && perm_rd;
         rsp_wr    <= req_valid && lk_ok && perm_wr;
         rsp_exec  <= req_valid && lk_ok && perm_x;
         rsp_swap  <= req_valid && lk_ok && !req_fetch && win_flags.swap;
         if (req_valid && !lk_ok) tag_access <= ta_next;
         if (req_valid && (lk_fault || lk_prot)) begin
            fault_status <= st_next;
            fault_addr   <= req_va;
         end
      end
   end

   assign used_bits = used_q;

   // ---------------- assertions ----------------
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault, rsp_prot}) == 1);

   a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault || rsp_prot));

   a_r5_pa_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_pa[PAGE_SHIFT-1:0] == '0);

   a_r12_swap_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_swap |-> rsp_hit && !rsp_exec);

   a_r9_status_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_prot) |-> fault_status[ST_VALID]);

   a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_fault || rsp_prot) && $past(fault_status[ST_VALID])) |-> fault_status[ST_OVF]);

   a_r10_miss_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> $stable(fault_status) && $stable(fault_addr));

   a_r13_used_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> used_bits != '0);
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
   localparam int N    = 16;
   localparam int VAW  = 64;
   localparam int PAW  = 41;
   localparam int CW   = 13;
   localparam int IW   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic           wr_en = 0;
   logic [IW-1:0]  wr_idx = '0;
   logic [VAW-1:0] wr_tag = '0;
   logic wr_valid = 0, wr_global = 0, wr_priv = 0, wr_writable = 0;
   logic wr_side_eff = 0, wr_nfo = 0, wr_swap = 0;
   logic [1:0]     wr_size = '0;
   logic [PAW-1:0] wr_pa = '0;
   logic [CW-1:0]  primary_ctx = '0, secondary_ctx = '0;
   logic           req_valid = 0, req_fetch = 0, req_user = 0, req_priv_mode = 0, req_tl_nz = 0;
   logic [VAW-1:0] req_va = '0;
   logic [1:0]     req_kind = '0, req_ctx_sel = '0;
   logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot, rsp_rd, rsp_wr, rsp_exec, rsp_swap;
   logic [PAW-1:0] rsp_pa;
   logic [9:0]     fault_status;
   logic [VAW-1:0] fault_addr, tag_access;
   logic [N-1:0]   used_bits;

   tlb_xlate #(.N_ENTRIES(N), .VA_W(VAW), .PA_W(PAW), .CTX_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
      .wr_valid(wr_valid), .wr_global(wr_global), .wr_size(wr_size), .wr_priv(wr_priv),
      .wr_writable(wr_writable), .wr_side_eff(wr_side_eff), .wr_nfo(wr_nfo),
      .wr_swap(wr_swap), .wr_pa(wr_pa), .primary_ctx(primary_ctx),
      .secondary_ctx(secondary_ctx), .req_valid(req_valid), .req_va(req_va),
      .req_fetch(req_fetch), .req_kind(req_kind), .req_ctx_sel(req_ctx_sel),
      .req_user(req_user), .req_priv_mode(req_priv_mode), .req_tl_nz(req_tl_nz),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_fault(rsp_fault), .rsp_prot(rsp_prot), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd),
      .rsp_wr(rsp_wr), .rsp_exec(rsp_exec), .rsp_swap(rsp_swap),
      .fault_status(fault_status), .fault_addr(fault_addr), .tag_access(tag_access),
      .used_bits(used_bits));

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [VAW-1:0] m_tag [N];
   logic [PAW-1:0] m_pa  [N];
   logic [8:0]     m_fl  [N];   // {valid,global,size[1:0],priv,writable,side_eff,nfo,swap}
   logic [N-1:0]   m_used;
   logic [9:0]     m_st;
   logic [VAW-1:0] m_far, m_ta;

   task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [63:0] pmask(logic [1:0] s);
      return ~((64'd1 << (13 + 3 * int'(s))) - 64'd1);
   endfunction

   task automatic wr_entry(int idx, logic [63:0] tag, logic v, logic g, logic [1:0] sz,
                           logic pr, logic wt, logic se, logic nf, logic sw, logic [40:0] pa);
      @(negedge clk);
      wr_en = 1; wr_idx = IW'(idx); wr_tag = tag; wr_valid = v; wr_global = g; wr_size = sz;
      wr_priv = pr; wr_writable = wt; wr_side_eff = se; wr_nfo = nf; wr_swap = sw; wr_pa = pa;
      @(negedge clk);
      wr_en = 0;
      m_tag[idx] = tag; m_pa[idx] = pa; m_fl[idx] = {v, g, sz, pr, wt, se, nf, sw};
      m_used[idx] = 1'b0;
   endtask

   task automatic do_req(string rq, logic [63:0] va, logic fetch, logic [1:0] kind,
                         logic [1:0] sel, logic user, logic pm, logic tlnz);
      logic [12:0] ctx;
      logic [1:0]  ctype;
      int          w;
      logic [3:0]  e_out;
      logic [40:0] e_pa;
      logic        e_rd, e_wr, e_x, e_sw, fp, fse, fnfo, flt, prt;
      logic [63:0] mk;
      @(negedge clk);
      req_valid = 1; req_va = va; req_fetch = fetch; req_kind = kind; req_ctx_sel = sel;
      req_user = user; req_priv_mode = pm; req_tl_nz = tlnz;
      @(negedge clk);
      req_valid = 0;
      // expected result from the model state before this request
      if (fetch) begin
         ctx = tlnz ? 13'd0 : primary_ctx; ctype = tlnz ? 2'd2 : 2'd0;
      end else if (sel == 2'd0) begin
         ctx = primary_ctx; ctype = 2'd0;
      end else if (sel == 2'd1) begin
         ctx = secondary_ctx; ctype = 2'd1;
      end else begin
         ctx = 13'd0; ctype = 2'd2;
      end
      w = -1;
      for (int i = N - 1; i >= 0; i--) begin
         mk = pmask(m_fl[i][6:5]);
         if (m_fl[i][8] && (m_fl[i][7] || m_tag[i][12:0] == ctx) && ((va & mk) == (m_tag[i] & mk)))
            w = i;
      end
      e_pa = '0; e_rd = 0; e_wr = 0; e_x = 0; e_sw = 0;
      if (w < 0) begin
         e_out = 4'b0100;
         m_ta = {va[63:13], ctx};
      end else begin
         fp   = m_fl[w][4] && user;
         fse  = !fetch && kind == 2'd2 && m_fl[w][2];
         fnfo = !fetch && kind != 2'd2 && m_fl[w][1];
         flt  = fp || fse || fnfo;
         prt  = !flt && !fetch && kind == 2'd1 && !m_fl[w][3];
         if (flt || prt) begin
            e_out = flt ? 4'b0010 : 4'b0001;
            m_st = {fnfo, fse, fp, !fetch && kind == 2'd2, !fetch && kind == 2'd1,
                    ctype, pm, m_st[0], 1'b1};
            m_far = va;
            m_ta = {va[63:13], ctx};
         end else begin
            e_out = 4'b1000;
            mk = pmask(m_fl[w][6:5]);
            e_pa = 41'((({23'd0, m_pa[w]} & mk) | (va & ~mk)) & ~64'h1fff);
            e_rd = !fetch; e_wr = !fetch && m_fl[w][3]; e_x = fetch; e_sw = !fetch && m_fl[w][0];
            m_used[w] = 1'b1;
         end
      end
      chk(rq, "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rq, "outcome{hit,miss,fault,prot}", 64'({rsp_hit, rsp_miss, rsp_fault, rsp_prot}), 64'(e_out));
      chk(rq, "rsp_pa", 64'(rsp_pa), 64'(e_pa));
      chk(rq, "perm{rd,wr,x,swap}", 64'({rsp_rd, rsp_wr, rsp_exec, rsp_swap}), 64'({e_rd, e_wr, e_x, e_sw}));
      chk(rq, "fault_status", 64'(fault_status), 64'(m_st));
      chk(rq, "fault_addr", fault_addr, m_far);
      chk(rq, "tag_access", tag_access, m_ta);
      chk(rq, "used_bits", 64'(used_bits), 64'(m_used));
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0011));
      for (int i = 0; i < N; i++) begin
         m_tag[i] = '0; m_pa[i] = '0; m_fl[i] = '0;
      end
      m_used = '0; m_st = '0; m_far = '0; m_ta = '0;
      primary_ctx = 13'd5; secondary_ctx = 13'd9;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "fault_status", 64'(fault_status), 64'd0);
      chk("R1", "fault_addr", fault_addr, 64'd0);
      chk("R1", "tag_access", tag_access, 64'd0);
      chk("R1", "used_bits", 64'(used_bits), 64'd0);

      // R2 R10: empty table misses, status untouched
      do_req("R10", 64'h0000_1234_5678_9abc, 0, 2'd0, 2'd0, 0, 0, 0);

      // R3 R5: 4 MB page, hand-computed physical address
      wr_entry(2, 64'h0000_1234_5680_0005, 1, 0, 2'd3, 0, 1, 0, 0, 0, 41'h0AB_C000_0000);
      do_req("R5", 64'h0000_1234_56A5_6000, 0, 2'd0, 2'd0, 0, 0, 0);
      chk("R5", "rsp_pa literal", 64'(rsp_pa), 64'h0AB_C025_6000);
      // R6: secondary context 9 mismatches entry context 5
      do_req("R6", 64'h0000_1234_56A5_6000, 0, 2'd0, 2'd1, 0, 0, 0);
      // R3: global entry ignores context
      wr_entry(3, 64'h0000_0000_0040_0007, 1, 1, 2'd0, 0, 0, 0, 0, 1, 41'h1_0000_2000);
      do_req("R3", 64'h0000_0000_0040_0010, 0, 2'd2, 2'd2, 0, 0, 0);
      // R4: lower index 1 overlaps entry 3
      wr_entry(1, 64'h0000_0000_0040_0000, 1, 1, 2'd1, 0, 1, 0, 0, 0, 41'h0_7777_0000);
      do_req("R4", 64'h0000_0000_0040_0010, 0, 2'd0, 2'd0, 0, 0, 0);
      // R12: data hit with swap (entry 1 shadowed? use other addr on entry 3 page only)
      wr_entry(1, 64'h0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 41'h0);
      do_req("R12", 64'h0000_0000_0040_1000, 0, 2'd0, 2'd0, 0, 0, 0);
      // R8: store to non-writable page
      do_req("R8", 64'h0000_0000_0040_1000, 0, 2'd1, 2'd0, 0, 1, 0);
      // R7 R9: multiple fault bits plus overflow
      wr_entry(4, 64'h0000_0000_0800_0005, 1, 0, 2'd0, 1, 1, 1, 1, 0, 41'h2_0000_0000);
      do_req("R7", 64'h0000_0000_0800_0000, 0, 2'd1, 2'd0, 1, 0, 0);
      do_req("R9", 64'h0000_0000_0800_0000, 0, 2'd2, 2'd0, 1, 1, 0);
      // R11: fetch, user on privileged page, and nucleus context
      do_req("R11", 64'h0000_0000_0800_0000, 1, 2'd2, 2'd1, 1, 0, 0);
      wr_entry(5, 64'h0000_0000_0900_0000, 1, 0, 2'd2, 0, 1, 1, 1, 1, 41'h3_0000_0000);
      do_req("R11", 64'h0000_0000_0900_4000, 1, 2'd1, 2'd0, 0, 0, 1);
      do_req("R6", 64'h0000_0000_0900_4000, 1, 2'd0, 2'd0, 0, 0, 0);
      // R13: rewrite clears used bit
      wr_entry(5, 64'h0000_0000_0900_0000, 1, 0, 2'd2, 0, 1, 0, 0, 0, 41'h3_0000_0000);
      chk("R13", "used_bits after write", 64'(used_bits), 64'(m_used));

      // constrained random phase
      for (int it = 0; it < 600; it++) begin
         if ($urandom_range(0, 3) == 0) begin
            logic [63:0] t;
            t = (64'($urandom_range(0, 3)) << 24) | (64'($urandom) & 64'hFF_E000)
                | 64'($urandom_range(0, 2));
            wr_entry(int'($urandom_range(0, N - 1)), t, $urandom_range(0, 7) != 0,
                     $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
                     $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                     $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
                     $urandom_range(0, 1) == 1, {9'($urandom), 32'($urandom)});
         end else begin
            logic [63:0] va;
            if ($urandom_range(0, 9) < 7)
               va = (m_tag[$urandom_range(0, N - 1)] & ~64'h1fff) | (64'($urandom) & 64'h7_E000);
            else
               va = {32'($urandom), 32'($urandom)};
            primary_ctx   = 13'($urandom_range(0, 2));
            secondary_ctx = 13'($urandom_range(0, 2));
            do_req("R2", va, $urandom_range(0, 3) == 0, 2'($urandom_range(0, 2)),
                   2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
                   $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule